// File: doc/BRIEF.md
# CAM Command Decoder and Address Sequencer

This block sits on the command write port of a small content-addressable memory. It accepts 16-bit command words and sorts them into four groups: data move, validity control, compare and special. For each accepted command it issues a one-cycle execute strobe together with decoded source, destination, mask, validity and sub-operation fields. These fields drive the memory array and the datapath, which lie outside this block.

A move or validity command can set an address flag (bit 11). The command then takes two words, and the second word carries an absolute memory address. The block owns a pair of banked address registers. The address register of the active bank steps by one after each operation that indexes memory, in a direction chosen per bank by a control bit. Special commands switch the active bank and request a reset of the segment counters.

Top module: `cam_cmd_seq`

## Requirements
- R1: One cycle after a legal command is accepted (with `cmd_we` high at a rising edge), `exec` pulses for one cycle. `op_kind` is then 0 for move, 1 for validity, 2 for compare and 3 for special.
- R1 field rules, by group (bits are of the command word):
  - Move (bits 15:12 = 0, bits 10:8 = 011): `msk` = bits 7:6 and `dst` = bits 5:3. A destination code with bit 2 set is a memory location. For a memory destination, `src` = {0, bits 1:0} and `vfield` = {00, bit 2}. Otherwise `src` = bits 2:0 and `vfield` = 0.
  - Validity (bits 15:12 = 0, bits 10:8 = 100, bits 7:6 = 0): `dst` = bits 5:3 and `vfield` = bits 2:0.
  - Compare (bits 15:8 = 0x05, bits 7:3 = 0): `vfield` = bits 2:0.
  - Special (bits 15:8 = 0x06, bits 7:6 = 0): `dst` = bits 5:3 and `spc_op` = bits 2:0.
- R2: A first word that matches no group makes `illegal` pulse for one cycle. It gives no `exec` and changes neither the bank nor the address.
- R3: A move or validity word with bit 11 set raises `busy` from the next cycle and gives no `exec`. The next write is taken as the address. Its low AW bits are loaded into the active bank's address register, `busy` drops, and the held command then executes as in R1.
- R4: Two cases index memory: a move whose destination (or, for a register destination, whose source) is code 100 or 101, and a validity command whose destination is code 100 or 101. After such a command, `addr` changes one cycle after `exec`. It decrements if `dir_down[bank]` is 1 and increments otherwise, wrapping modulo 2^AW.
- R5: Compare, special and non-indexing move or validity commands leave `addr` unchanged.
- R6: A move with a register destination (bit 5 = 0) and bits 2:0 equal to bits 5:3 is a no-op: no `exec` and no step. If bit 11 was set, the address word is still loaded.
- R7: Special `spc_op` 000 selects bank 0 and 001 selects bank 1. Each bank has its own address register, and `addr` shows the active one.
- R8: Special `spc_op` 010 pulses `seg_rst` for one cycle, together with `exec`.
- R9: After reset, `busy`, `exec`, `illegal` and `seg_rst` are low, `bank` is 0 and both address registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command or address word |
| dir_down | input | 2 | Per-bank step direction, 1 = decrement |
| busy | output | 1 | Waiting for the address word |
| exec | output | 1 | Decoded command valid this cycle |
| illegal | output | 1 | Unrecognised command pulse |
| seg_rst | output | 1 | Segment counter reload pulse |
| bank | output | 1 | Active configuration bank |
| op_kind | output | 2 | Command group |
| dst | output | 3 | Destination or special target |
| src | output | 3 | Source code |
| msk | output | 2 | Mask select |
| vfield | output | 3 | Validity setting or condition |
| spc_op | output | 3 | Special sub-operation |
| addr | output | AW | Active address register |

## Verification
The assertions check on every cycle that the address moves only after an execute, an address load or a bank switch. They also check that `busy` holds until a write arrives, and that bank changes and counter-reload pulses occur only alongside a matching special execute. Only the bench scenarios can show the actual decoded field values, the step direction and the wrap at both ends. The same is true of the no-op move and of the loaded address value, which the bench compares against a reference model driven by directed words and seeded random words.

// File: rtl/cam_cmd_seq.sv
module cam_cmd_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [15:0]   cmd_word,
  input  logic [1:0]    dir_down,
  output logic          busy,
  output logic          exec,
  output logic          illegal,
  output logic          seg_rst,
  output logic          bank,
  output logic [1:0]    op_kind,
  output logic [2:0]    dst,
  output logic [2:0]    src,
  output logic [1:0]    msk,
  output logic [2:0]    vfield,
  output logic [2:0]    spc_op,
  output logic [AW-1:0] addr
);
  logic        pend;
  logic [15:0] hold;
  logic        step_q;
  logic [AW-1:0] ar [2];

  wire [15:0] w      = pend ? hold : cmd_word;
  wire        top0   = w[15:12] == 4'h0;
  wire        is_mov = top0 && w[10:8] == 3'b011;
  wire        is_vbc = top0 && w[10:8] == 3'b100 && w[7:6] == 2'b00;
  wire        is_cmp = w[15:8] == 8'h05 && w[7:3] == 5'd0;
  wire        is_spc = w[15:8] == 8'h06 && w[7:6] == 2'b00;
  wire        legal  = is_mov | is_vbc | is_cmp | is_spc;
  wire        dmem   = w[5];
  wire        idx_d  = w[5:4] == 2'b10;
  wire        idx_s  = w[2:1] == 2'b10;
  wire        mv_nop = is_mov && !dmem && w[2:0] == w[5:3];
  wire        steps  = (is_mov && (dmem ? idx_d : idx_s)) || (is_vbc && idx_d);
  wire        two_wd = !pend && w[11] && (is_mov || is_vbc);
  wire        issue  = cmd_we && legal && !two_wd;
  wire        ld     = cmd_we && pend;

  assign busy = pend;
  assign addr = ar[bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      hold    <= '0;
      exec    <= 1'b0;
      illegal <= 1'b0;
      seg_rst <= 1'b0;
      step_q  <= 1'b0;
      bank    <= 1'b0;
      op_kind <= '0;
      dst     <= '0;
      src     <= '0;
      msk     <= '0;
      vfield  <= '0;
      spc_op  <= '0;
    end else begin
      exec    <= issue && !mv_nop;
      illegal <= cmd_we && !pend && !legal;
      seg_rst <= issue && is_spc && w[2:0] == 3'b010;
      step_q  <= issue && steps;
      if (cmd_we) pend <= two_wd;
      if (two_wd && cmd_we) hold <= w;
      if (issue && is_spc && w[2:1] == 2'b00) bank <= w[0];
      if (issue && !mv_nop) begin
        op_kind <= is_mov ? 2'd0 : is_vbc ? 2'd1 : is_cmp ? 2'd2 : 2'd3;
        dst     <= w[5:3];
        src     <= !is_mov ? 3'd0 : dmem ? {1'b0, w[1:0]} : w[2:0];
        msk     <= is_mov ? w[7:6] : 2'd0;
        vfield  <= is_mov ? (dmem ? {2'b00, w[2]} : 3'd0)
                          : (is_vbc || is_cmp) ? w[2:0] : 3'd0;
        spc_op  <= is_spc ? w[2:0] : 3'd0;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ar[g] <= '0;
      else if (ld && bank == 1'(g))
        ar[g] <= cmd_word[AW-1:0];
      else if (step_q && bank == 1'(g))
        ar[g] <= dir_down[g] ? ar[g] - 1'b1 : ar[g] + 1'b1;
    end
  end
endmodule

// File: rtl/cam_cmd_seq_chk.sv
module cam_cmd_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic          busy,
  input logic          exec,
  input logic          illegal,
  input logic          seg_rst,
  input logic          bank,
  input logic [1:0]    op_kind,
  input logic [2:0]    spc_op,
  input logic [AW-1:0] addr
);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_we |=> busy);
  p_first_word_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !exec && !illegal);
  p_illegal_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !exec && !seg_rst && !busy);
  p_addr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exec) && !$fell(busy) && $stable(bank) |-> $stable(addr));
  p_cmp_no_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op_kind == 2'd2 |=> $stable(addr) || !$stable(bank));
  p_bank_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> exec && op_kind == 2'd3 && spc_op[2:1] == 2'b00);
  p_seg_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_rst |-> exec && op_kind == 2'd3 && spc_op == 3'b010);
endmodule

bind cam_cmd_seq cam_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .busy(busy), .exec(exec),
  .illegal(illegal), .seg_rst(seg_rst), .bank(bank), .op_kind(op_kind),
  .spc_op(spc_op), .addr(addr)
);

// File: tb/cam_cmd_seq_tb.sv
`timescale 1ns/1ps
module cam_cmd_seq_tb;
  localparam int AW = 10;
  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [1:0]  dir_down = '0;
  logic busy, exec, illegal, seg_rst, bank;
  logic [1:0] op_kind, msk;
  logic [2:0] dst, src, vfield, spc_op;
  logic [AW-1:0] addr;

  cam_cmd_seq #(.AW(AW)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_ar [2];
  logic m_bank, m_pend;
  logic [15:0] m_hold;
  logic e_exec, e_ill, e_seg, e_step;
  logic [1:0] e_kind, e_msk;
  logic [2:0] e_dst, e_src, e_vf, e_sop;

  task automatic chk(string r, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, nm, act, exp);
    end
  endtask

  function automatic bit f_mov(logic [15:0] w); return (w & 16'hF700) == 16'h0300; endfunction
  function automatic bit f_vbc(logic [15:0] w); return (w & 16'hF7C0) == 16'h0400; endfunction
  function automatic bit f_cmp(logic [15:0] w); return (w & 16'hFFF8) == 16'h0500; endfunction
  function automatic bit f_spc(logic [15:0] w); return (w & 16'hFFC0) == 16'h0600; endfunction
  function automatic bit f_idx(logic [2:0] c); return c == 3'd4 || c == 3'd5; endfunction

  task automatic ref_issue(logic [15:0] w);
    if (f_mov(w) && !w[5] && w[2:0] == w[5:3]) return;
    e_exec = 1; e_dst = w[5:3]; e_src = 0; e_msk = 0; e_vf = 0; e_sop = 0;
    if (f_mov(w)) begin
      e_kind = 0; e_msk = w[7:6];
      e_src = w[5] ? {1'b0, w[1:0]} : w[2:0];
      e_vf  = w[5] ? {2'b00, w[2]} : 3'd0;
      e_step = w[5] ? f_idx(w[5:3]) : f_idx(w[2:0]);
    end else if (f_vbc(w)) begin
      e_kind = 1; e_vf = w[2:0]; e_step = f_idx(w[5:3]);
    end else if (f_cmp(w)) begin
      e_kind = 2; e_vf = w[2:0];
    end else begin
      e_kind = 3; e_sop = w[2:0];
      if (w[2:0] == 3'd0) m_bank = 0;
      if (w[2:0] == 3'd1) m_bank = 1;
      if (w[2:0] == 3'd2) e_seg = 1;
    end
  endtask

  task automatic apply(logic [15:0] w, string r);
    logic legal;
    legal = f_mov(w) || f_vbc(w) || f_cmp(w) || f_spc(w);
    e_exec = 0; e_ill = 0; e_seg = 0; e_step = 0;
    if (m_pend) begin
      m_ar[m_bank] = w[AW-1:0]; m_pend = 0; ref_issue(m_hold);
    end else if (!legal) e_ill = 1;
    else if (w[11] && (f_mov(w) || f_vbc(w))) begin m_pend = 1; m_hold = w; end
    else ref_issue(w);
    @(negedge clk); cmd_we = 1; cmd_word = w;
    @(negedge clk); cmd_we = 0;
    chk(r, "exec", 32'(exec), 32'(e_exec));
    chk(r, "illegal", 32'(illegal), 32'(e_ill));
    chk(r, "seg_rst", 32'(seg_rst), 32'(e_seg));
    chk(r, "busy", 32'(busy), 32'(m_pend));
    chk(r, "bank", 32'(bank), 32'(m_bank));
    chk(r, "addr", 32'(addr), 32'(m_ar[m_bank]));
    if (e_exec) begin
      chk(r, "op_kind", 32'(op_kind), 32'(e_kind));
      chk(r, "dst", 32'(dst), 32'(e_dst));
      chk(r, "src", 32'(src), 32'(e_src));
      chk(r, "msk", 32'(msk), 32'(e_msk));
      chk(r, "vfield", 32'(vfield), 32'(e_vf));
      chk(r, "spc_op", 32'(spc_op), 32'(e_sop));
    end
    if (e_step)
      m_ar[m_bank] = dir_down[m_bank] ? m_ar[m_bank] - 1'b1 : m_ar[m_bank] + 1'b1;
    @(negedge clk);
    chk(r, "exec_end", 32'(exec), 32'd0);
    chk(e_step ? "R4" : r, "addr_after", 32'(addr), 32'(m_ar[m_bank]));
  endtask

  function automatic logic [15:0] gen();
    logic [15:0] w;
    int k;
    k = $urandom % 10;
    w = 16'($urandom);
    case (k)
      0, 1, 2: w = {4'h0, ($urandom % 4 == 0), 3'b011, w[7:0]};
      3, 4:    w = {4'h0, ($urandom % 4 == 0), 3'b100, 2'b00, w[5:0]};
      5:       w = {13'h00A0, w[2:0]};
      6:       w = {10'h018, w[5:0]};
      7:       w = {13'h00C0, 1'b0, w[1:0]};
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ar[0] = '0; m_ar[1] = '0; m_bank = 0; m_pend = 0; m_hold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "busy", 32'(busy), 0);
    chk("R9", "exec", 32'(exec), 0);
    chk("R9", "illegal", 32'(illegal), 0);
    chk("R9", "seg_rst", 32'(seg_rst), 0);
    chk("R9", "bank", 32'(bank), 0);
    chk("R9", "addr", 32'(addr), 0);
    apply(16'h0301, "R1");
    apply(16'h0309, "R6");
    apply(16'hFFFF, "R2");
    apply(16'h0508, "R2");
    dir_down = 2'b00;
    apply(16'h0C2B, "R3");
    apply(16'h03FF, "R3");
    dir_down = 2'b01;
    apply(16'h0421, "R4");
    apply(16'h0502, "R5");
    apply(16'h0601, "R7");
    apply(16'h0304, "R4");
    apply(16'h0600, "R7");
    apply(16'h0602, "R8");
    apply(16'h0376, "R1");
    apply(16'h0B09, "R6");
    apply(16'h0155, "R6");
    for (int i = 0; i < 600; i++) begin
      if (!m_pend && ($urandom % 16 == 0)) dir_down = 2'($urandom);
      apply(gen(), "R1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule